// File: doc/BRIEF.md
# Boot-Time Clock Distributor Configurator

This block runs once after reset and programs two external clock-distribution chips without any processor. Each chip has its own serial write port, made of data, an active-low chip select, an enable and a serial clock. One chain feeds the RF reference clocks and the other feeds the sampling and logic clocks. The serial clock is derived from the system clock. Each chain gets a fixed list of six 16-bit control words. The list is built from elaboration parameters, except for the clock-source word, which can instead come from an input pin sampled at boot.

While the two chains are being written, a status output stays high. It is wired as the reset of downstream clock managers, so they stay in reset until the external clocks are valid. A synchronous reset restarts the whole sequence.

Top module: `clkdist_boot_cfg`

## Requirements
- R1: While `rst` is high, `config_invalid` is 1, both chip selects are 1, both serial clocks are 0 and both enables are 0.
- R2: Both enable outputs go to 1 on the first clock edge after `rst` falls and stay at 1 until the next reset.
- R3: The first word of each chain selects the clock source. 0x1AFF selects the local oscillator and 0x1DFF selects the external coaxial input. If the chain's pin-mode parameter is 0, the source comes from the chain's source parameter (1 = coax). If it is 1, the source comes from the chain's source pin (1 = coax).
- R4: The source pins are registered once, on the first edge after reset release. Any later change to them has no effect on the words sent.
- R5: The RF chain sends, in order: the source word, its four output-mode words, then its forwarding word. The defaults are 0x01FF, 0x1EFF, 0x1EFF, 0x01FF, then 0x0BFF (outputs 4 and 7 off, outputs 5 and 6 on, forwarding off).
- R6: The logic chain sends, in order: the source word, its four output-mode words, then its forwarding word. The defaults are 0x02FF, 0x02FF, 0x08FF, 0x08FF, then 0x1FFF (outputs 0 and 1 off, outputs 2 and 3 at full drive, forwarding off).
- R7: Each word is framed by chip select low for exactly 16 rising serial clock edges, MSB first. Data changes only while the serial clock is low or on its falling edge. The serial clock is low whenever chip select is high.
- R8: Between two words, chip select stays high for at least one serial clock period. Each word occupies WORD_CYC (default 40) system clock cycles.
- R9: The serial clock period is 2*HALF system cycles. HALF is the largest value for which the period is at most SYS_CLK_HZ/SER_MIN_HZ and the 16 bits plus one idle period fit in WORD_CYC. With the defaults this gives a period of 2 cycles, so chip select is low for 32 cycles per word.
- R10: `config_invalid` falls on the (2 + 6*WORD_CYC)th rising edge after reset release, which is after both chains have sent all six words. It then stays low until the next reset.
- R11: Asserting `rst` in the middle of the sequence aborts it, raises `config_invalid` again, and after release the full sequence runs again from the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_src_pin | input | 1 | RF chain source select pin (1 = coax), used in pin mode |
| lg_src_pin | input | 1 | Logic chain source select pin (1 = coax), used in pin mode |
| rf_ser_dat | output | 1 | RF chain serial data |
| rf_ser_cs_n | output | 1 | RF chain chip select, active low |
| rf_ser_en | output | 1 | RF chain chip enable |
| rf_ser_sclk | output | 1 | RF chain serial clock |
| lg_ser_dat | output | 1 | Logic chain serial data |
| lg_ser_cs_n | output | 1 | Logic chain chip select, active low |
| lg_ser_en | output | 1 | Logic chain chip enable |
| lg_ser_sclk | output | 1 | Logic chain serial clock |
| config_invalid | output | 1 | High until both chains are configured; drives downstream resets |

## Verification
The bench uses the RF chain in pin mode and the logic chain in parameter mode with coax selected. It walks all four combinations of the two source pins. Each combination shows whether the RF source word follows its pin and whether the logic source word ignores its own pin.

Further vectors flip the pins right after the boot sample. These separate a design that captures the pins once from one that keeps reading them live.

Every word on both ports is rebuilt from the serial waveform and compared against the expected list. This exposes errors in bit order, word order and per-chain content. A directed mid-sequence reset then confirms that the sequence restarts from the first word.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;

    localparam int WORD_W   = 16;
    localparam int NUM_WORDS = 6;
    localparam int IDX_W    = 3;

    localparam logic [WORD_W-1:0] SRC_OSC_WORD  = 16'h1AFF;
    localparam logic [WORD_W-1:0] SRC_COAX_WORD = 16'h1DFF;

    // Largest half period (in system cycles) such that the serial clock is
    // not slower than the minimum rate and 16 bits plus one idle serial
    // period fit inside one word slot.
    function automatic int calc_half(input int sys_hz, input int ser_hz, input int word_cyc);
        int best;
        best = 1;
        for (int h = 16; h >= 1; h--) begin
            if ((2 * h * ser_hz <= sys_hz) && ((2 * WORD_W + 2) * h <= word_cyc) && (best == 1) && (h > 1))
                best = h;
        end
        return best;
    endfunction

endpackage

// File: rtl/clkdist_word_sel.sv
module clkdist_word_sel
    import clkdist_pkg::*;
#(
    parameter bit                      FROM_PIN = 1'b0,
    parameter bit                      SRC_COAX = 1'b0,
    parameter logic [3:0][WORD_W-1:0]  OUT_MODES = '0,
    parameter logic [WORD_W-1:0]       FWD_MODE = '0
) (
    input  logic              pin_q,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    logic use_coax;

    generate
        if (FROM_PIN) begin : g_pin_src
            assign use_coax = pin_q;
        end else begin : g_param_src
            logic unused_pin;
            assign unused_pin = pin_q;
            assign use_coax   = SRC_COAX;
        end
    endgenerate

    always_comb begin
        case (idx)
            3'd0:    word = use_coax ? SRC_COAX_WORD : SRC_OSC_WORD;
            3'd1:    word = OUT_MODES[0];
            3'd2:    word = OUT_MODES[1];
            3'd3:    word = OUT_MODES[2];
            3'd4:    word = OUT_MODES[3];
            3'd5:    word = FWD_MODE;
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/clkdist_ser_tx.sv
module clkdist_ser_tx
    import clkdist_pkg::*;
#(
    parameter int WORD_CYC = 40,
    parameter int HALF     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx,
    output logic              cs_n,
    output logic              sclk,
    output logic              dat,
    output logic              done
);

    localparam int CNT_W   = $clog2(WORD_CYC);
    localparam int BIT_CYC = 2 * HALF;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_CYC - 1);
    localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(WORD_W * BIT_CYC);
    localparam logic [CNT_W-1:0] BIT_CYC_C = CNT_W'(BIT_CYC);
    localparam logic [CNT_W-1:0] HALF_C    = CNT_W'(HALF);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy && !st_q.done && start) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                if (st_q.idx == IDX_LAST) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    logic             frame;
    logic [3:0]       bit_no;
    logic [CNT_W-1:0] phase;

    always_comb begin
        frame  = st_q.busy && (st_q.cnt < LOW_END);
        bit_no = 4'(st_q.cnt / BIT_CYC_C);
        phase  = st_q.cnt % BIT_CYC_C;
        cs_n   = !frame;
        sclk   = frame && (phase >= HALF_C);
        dat    = frame ? word[4'd15 - bit_no] : 1'b0;
        idx    = st_q.idx;
        done   = st_q.done;
    end

    a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    a_r7_dat_held_high: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(dat));
    a_r8_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done && cs_n);

endmodule

// File: rtl/clkdist_boot_cfg.sv
module clkdist_boot_cfg
    import clkdist_pkg::*;
#(
    parameter int                     SYS_CLK_HZ      = 100_000_000,
    parameter int                     SER_MIN_HZ      = 25_000_000,
    parameter int                     WORD_CYC        = 40,
    parameter bit                     RF_SRC_FROM_PIN = 1'b0,
    parameter bit                     LG_SRC_FROM_PIN = 1'b0,
    parameter bit                     RF_SRC_COAX     = 1'b0,
    parameter bit                     LG_SRC_COAX     = 1'b0,
    parameter logic [3:0][WORD_W-1:0] RF_OUT_MODES    = {16'h01FF, 16'h1EFF, 16'h1EFF, 16'h01FF},
    parameter logic [3:0][WORD_W-1:0] LG_OUT_MODES    = {16'h08FF, 16'h08FF, 16'h02FF, 16'h02FF},
    parameter logic [WORD_W-1:0]      RF_FWD_MODE     = 16'h0BFF,
    parameter logic [WORD_W-1:0]      LG_FWD_MODE     = 16'h1FFF
) (
    input  logic clk,
    input  logic rst,
    input  logic rf_src_pin,
    input  logic lg_src_pin,
    output logic rf_ser_dat,
    output logic rf_ser_cs_n,
    output logic rf_ser_en,
    output logic rf_ser_sclk,
    output logic lg_ser_dat,
    output logic lg_ser_cs_n,
    output logic lg_ser_en,
    output logic lg_ser_sclk,
    output logic config_invalid
);

    localparam int HALF   = calc_half(SYS_CLK_HZ, SER_MIN_HZ, WORD_CYC);
    localparam int NCHAIN = 2;

    typedef struct packed {
        logic             en;
        logic             started;
        logic [NCHAIN-1:0] sel;
    } boot_state_t;

    boot_state_t bs_d, bs_q;

    always_comb begin
        bs_d         = bs_q;
        bs_d.en      = 1'b1;
        bs_d.started = 1'b1;
        if (!bs_q.started)
            bs_d.sel = {lg_src_pin, rf_src_pin};
    end

    always_ff @(posedge clk) begin
        if (rst) bs_q <= '0;
        else     bs_q <= bs_d;
    end

    logic [NCHAIN-1:0] ch_cs_n, ch_sclk, ch_dat, ch_done;

    for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;

        clkdist_word_sel #(
            .FROM_PIN (c == 0 ? RF_SRC_FROM_PIN : LG_SRC_FROM_PIN),
            .SRC_COAX (c == 0 ? RF_SRC_COAX : LG_SRC_COAX),
            .OUT_MODES(c == 0 ? RF_OUT_MODES : LG_OUT_MODES),
            .FWD_MODE (c == 0 ? RF_FWD_MODE : LG_FWD_MODE)
        ) u_word_sel (
            .pin_q(bs_q.sel[c]),
            .idx  (idx),
            .word (word)
        );

        clkdist_ser_tx #(
            .WORD_CYC(WORD_CYC),
            .HALF    (HALF)
        ) u_ser_tx (
            .clk  (clk),
            .rst  (rst),
            .start(bs_q.started),
            .word (word),
            .idx  (idx),
            .cs_n (ch_cs_n[c]),
            .sclk (ch_sclk[c]),
            .dat  (ch_dat[c]),
            .done (ch_done[c])
        );
    end

    always_comb begin
        rf_ser_dat     = ch_dat[0];
        rf_ser_cs_n    = ch_cs_n[0];
        rf_ser_sclk    = ch_sclk[0];
        rf_ser_en      = bs_q.en;
        lg_ser_dat     = ch_dat[1];
        lg_ser_cs_n    = ch_cs_n[1];
        lg_ser_sclk    = ch_sclk[1];
        lg_ser_en      = bs_q.en;
        config_invalid = !(&ch_done);
    end

    a_r2_en_held: assert property (@(posedge clk) disable iff (rst)
        rf_ser_en |=> rf_ser_en && lg_ser_en);
    a_r4_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        bs_q.started |=> $stable(bs_q.sel));
    a_r10_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        !config_invalid |=> !config_invalid);
    a_r10_idle_when_valid: assert property (@(posedge clk) disable iff (rst)
        !config_invalid |-> rf_ser_cs_n && lg_ser_cs_n);

endmodule

// File: tb/clkdist_boot_cfg_bench.sv
module clkdist_boot_cfg_bench;

    localparam int WC       = 40;
    localparam int DONE_CYC = 2 + 6 * WC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rf_pin = 1'b0;
    logic lg_pin = 1'b0;
    logic rf_dat, rf_cs_n, rf_en, rf_sclk;
    logic lg_dat, lg_cs_n, lg_en, lg_sclk;
    logic cfg_inv;

    always #2 clk = ~clk;

    clkdist_boot_cfg #(
        .WORD_CYC       (WC),
        .RF_SRC_FROM_PIN(1'b1),
        .LG_SRC_FROM_PIN(1'b0),
        .LG_SRC_COAX    (1'b1)
    ) u_clkdist_boot_cfg (
        .clk(clk), .rst(rst),
        .rf_src_pin(rf_pin), .lg_src_pin(lg_pin),
        .rf_ser_dat(rf_dat), .rf_ser_cs_n(rf_cs_n), .rf_ser_en(rf_en), .rf_ser_sclk(rf_sclk),
        .lg_ser_dat(lg_dat), .lg_ser_cs_n(lg_cs_n), .lg_ser_en(lg_en), .lg_ser_sclk(lg_sclk),
        .config_invalid(cfg_inv)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // {pin_rf, pin_lg, flip_after_boot, expected rf source, expected lg source}
    localparam logic [34:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 16'h1AFF, 16'h1DFF},
        {1'b1, 1'b0, 1'b0, 16'h1DFF, 16'h1DFF},
        {1'b0, 1'b1, 1'b0, 16'h1AFF, 16'h1DFF},
        {1'b1, 1'b1, 1'b0, 16'h1DFF, 16'h1DFF},
        {1'b0, 1'b0, 1'b1, 16'h1AFF, 16'h1DFF},
        {1'b1, 1'b1, 1'b1, 16'h1DFF, 16'h1DFF}
    };

    logic [15:0] rf_fixed [5] = '{16'h01FF, 16'h1EFF, 16'h1EFF, 16'h01FF, 16'h0BFF};
    logic [15:0] lg_fixed [5] = '{16'h02FF, 16'h02FF, 16'h08FF, 16'h08FF, 16'h1FFF};

    // decoder state, index 0 = RF, 1 = logic
    logic        p_sclk [2];
    logic        p_cs   [2];
    logic        p_dat  [2];
    logic [15:0] sh     [2];
    int          nb     [2];
    int          nw     [2];
    logic [15:0] got    [2][8];
    int          gap    [2];
    int          min_gap[2];
    int          low_run[2];
    int          bad_low[2];
    int          bad_bits[2];
    int          bad_edge[2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic dec_clear();
        for (int c = 0; c < 2; c++) begin
            p_sclk[c] = 1'b0; p_cs[c] = 1'b1; p_dat[c] = 1'b0;
            sh[c] = '0; nb[c] = 0; nw[c] = 0; gap[c] = 0; min_gap[c] = 999;
            low_run[c] = 0; bad_low[c] = 0; bad_bits[c] = 0; bad_edge[c] = 0;
            for (int k = 0; k < 8; k++) got[c][k] = '0;
        end
    endtask

    task automatic dec_step(input int c, input logic sc, input logic cs, input logic d);
        if (cs && sc) bad_edge[c]++;
        if (sc && p_sclk[c] && d != p_dat[c]) bad_edge[c]++;
        if (sc && !p_sclk[c] && d != p_dat[c] && !p_cs[c]) bad_edge[c]++;
        if (!cs) begin
            if (p_cs[c]) begin
                if (nw[c] > 0 && gap[c] < min_gap[c]) min_gap[c] = gap[c];
                nb[c] = 0; low_run[c] = 0;
            end
            low_run[c]++;
            if (sc && !p_sclk[c]) begin
                sh[c] = {sh[c][14:0], d};
                nb[c]++;
            end
        end else begin
            if (!p_cs[c]) begin
                if (nw[c] < 8) got[c][nw[c]] = sh[c];
                nw[c]++;
                if (nb[c] != 16) bad_bits[c]++;
                if (low_run[c] != 32) bad_low[c]++;
                gap[c] = 0;
            end
            gap[c]++;
        end
        p_sclk[c] = sc; p_cs[c] = cs; p_dat[c] = d;
    endtask

    task automatic reset_state_check();
        check(cfg_inv == 1'b1, "R1 config_invalid in reset", cfg_inv, 1);
        check(rf_cs_n && lg_cs_n, "R1 chip selects in reset", {rf_cs_n, lg_cs_n}, 2'b11);
        check(!rf_sclk && !lg_sclk, "R1 serial clocks in reset", {rf_sclk, lg_sclk}, 0);
        check(!rf_en && !lg_en, "R1 enables in reset", {rf_en, lg_en}, 0);
    endtask

    task automatic run_case(input logic prf, input logic plg, input logic flip,
                            input logic [15:0] exp_rf, input logic [15:0] exp_lg);
        int inv_cyc;
        rst = 1'b1;
        rf_pin = prf; lg_pin = plg;
        repeat (3) @(negedge clk);
        reset_state_check();
        dec_clear();
        rst = 1'b0;
        inv_cyc = -1;
        for (int cyc = 1; cyc <= DONE_CYC + 20; cyc++) begin
            @(negedge clk);
            if (cyc == 1) begin
                check(rf_en && lg_en, "R2 enables after release", {rf_en, lg_en}, 2'b11);
                check(cfg_inv, "R10 invalid at start", cfg_inv, 1);
                if (flip) begin
                    rf_pin = ~prf; lg_pin = ~plg;
                end
            end
            dec_step(0, rf_sclk, rf_cs_n, rf_dat);
            dec_step(1, lg_sclk, lg_cs_n, lg_dat);
            if (!cfg_inv && inv_cyc < 0) inv_cyc = cyc;
            if (inv_cyc >= 0 && cfg_inv)
                check(1'b0, "R10 invalid re-raised", cfg_inv, 0);
        end
        check(rf_en && lg_en, "R2 enables held", {rf_en, lg_en}, 2'b11);
        check(inv_cyc == DONE_CYC, "R10 release cycle", inv_cyc, DONE_CYC);
        check(nw[0] == 6, "R5 rf word count", nw[0], 6);
        check(nw[1] == 6, "R6 lg word count", nw[1], 6);
        check(got[0][0] == exp_rf, flip ? "R4 rf source after pin flip" : "R3 rf source from pin",
              got[0][0], exp_rf);
        check(got[1][0] == exp_lg, flip ? "R4 lg source after pin flip" : "R3 lg source from parameter",
              got[1][0], exp_lg);
        for (int k = 0; k < 5; k++) begin
            check(got[0][k+1] == rf_fixed[k], "R5 rf word", got[0][k+1], rf_fixed[k]);
            check(got[1][k+1] == lg_fixed[k], "R6 lg word", got[1][k+1], lg_fixed[k]);
        end
        for (int c = 0; c < 2; c++) begin
            check(bad_bits[c] == 0, "R7 sixteen clocks per word", bad_bits[c], 0);
            check(bad_edge[c] == 0, "R7 data and clock edges", bad_edge[c], 0);
            check(min_gap[c] >= 2, "R8 chip select gap", min_gap[c], 2);
            check(bad_low[c] == 0, "R9 serial clock period", bad_low[c], 0);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        reset_state_check();

        for (int v = 0; v < 6; v++)
            run_case(VEC[v][34], VEC[v][33], VEC[v][32], VEC[v][31:16], VEC[v][15:0]);

        // R11: reset in mid-sequence, then a full clean run
        rst = 1'b1; rf_pin = 1'b1; lg_pin = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        check(cfg_inv, "R11 invalid mid-sequence", cfg_inv, 1);
        rst = 1'b1;
        @(negedge clk);
        check(cfg_inv && rf_cs_n && lg_cs_n && !rf_en, "R11 abort on reset",
              {cfg_inv, rf_cs_n, lg_cs_n, rf_en}, 4'b1110);
        run_case(1'b1, 1'b0, 1'b0, 16'h1DFF, 16'h1DFF);
        check(nw[0] == 6 && got[0][0] == 16'h1DFF, "R11 restart from first word", got[0][0], 16'h1DFF);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule